// File: doc/BRIEF.md
# Single-Channel DMA Transfer Controller

This block is one DMA channel that copies 32-bit words from a source to a destination without help from the processor. Either side may be ordinary memory or a single attached peripheral, but not both at once. Software sets a source address, a destination address, a byte count and a control word through a small register port. Setting the start bit in the control word begins the job.

Before it touches the system bus, the channel raises a bus request and waits for a grant. It can also ask the processor to snoop its cache, and it can give the bus back when the processor wants it. Each word is moved in two bus cycles: a read from the source into an internal holding register, then a write of that word to the destination. Every bus cycle uses a valid/ready handshake. Transfers run either back to back (internal mode) or one word at a time, paced by the peripheral's request line (external level mode). A single acknowledge line tells the peripheral when a bus cycle is addressed to it.

Top module: `dma_chan`

## Requirements
- R1: The register port decodes cfg_addr as follows: 0 is the source address, 1 is the destination address, 2 is the byte count and 3 is the control word. The low two bits of the byte count are always stored as 0. cfg_rdata shows the selected register one cycle after cfg_addr is applied. Writes to any register are ignored while the start bit is 1.
- R2: The control word carries these fields: bit 0 start, bit 1 external mode, bit 2 snoop, bit 3 yield, bit 4 source-is-peripheral, bit 5 destination-is-peripheral, bit 6 source hold, bit 7 destination hold. It also shows bit 8 done and bit 9 error, which are read-only. If start is written with both peripheral bits set, the start bit stays 0, error becomes 1 and no bus request is made.
- R3: pack_o is high only during a bus cycle that addresses the peripheral side. That is a read when the source is the peripheral, or a write when the destination is the peripheral.
- R4: bus_req_o rises before any bus cycle. m_valid_o is high only while both bus_req_o and bus_gnt_i are high.
- R5: bus_snoop_o equals bus_req_o when the snoop bit is 1, and stays 0 when the snoop bit is 0.
- R6: When the yield bit is 1 and bus_yield_i is high as a word's write completes, bus_req_o is low in the next cycle. When the yield bit is 0, bus_yield_i has no effect.
- R7: bus_req_o drops as soon as no transfer request is pending. In external mode this happens after the current word when preq_i is low.
- R8: In internal mode, an accepted start keeps words moving until the count reaches zero.
- R9: In external level mode, one word is moved for each decision point at which preq_i is sampled high. No bus request is made while preq_i stays low.
- R10: Each word is a read from the source address followed by a write to the destination address. The write carries the data returned by that read.
- R11: After each word, the source and destination addresses each advance by 4 unless their hold bit is set, and the count drops by 4. At a count of zero, start clears and done becomes 1.
- R12: While m_valid_o is high and m_ready_i is low, m_valid_o, m_addr_o and m_we_o hold steady in the next cycle.
- R13: A start with a byte count of 0 sets done at once and makes no bus request. An accepted start clears both done and error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Registered read data of the selected register |
| bus_req_o | output | 1 | System bus request |
| bus_snoop_o | output | 1 | Cache snoop request, valid with bus_req_o |
| bus_gnt_i | input | 1 | System bus grant |
| bus_yield_i | input | 1 | Processor asks for the bus back |
| m_valid_o | output | 1 | Bus cycle valid |
| m_we_o | output | 1 | 1 = write cycle, 0 = read cycle |
| m_addr_o | output | 32 | Bus byte address |
| m_wdata_o | output | 32 | Write data |
| m_rdata_i | input | 32 | Read data |
| m_ready_i | input | 1 | Bus cycle completes on this cycle |
| preq_i | input | 1 | Peripheral transfer request |
| pack_o | output | 1 | Peripheral acknowledge |
| done_o | output | 1 | Job finished |
| err_o | output | 1 | Start refused for a peripheral-to-peripheral job |

## Verification
The assertions check the bus-side rules on every cycle:
- the acknowledge appears only inside a bus cycle;
- a bus cycle appears only with request and grant held;
- snoop is never high without a request;
- addresses hold steady through wait states;
- every write follows a completed read;
- the request drops after a yielded word;
- no request accompanies a refused start.

Some behaviour only the bench's scenarios can show: the copied data, the final addresses and count, the level-mode pacing against preq_i, the register lock during a job and the release count with yield enabled or disabled. The bench checks these against values it computes itself, under random wait states and random grant delays.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR} dma_state_e;

  localparam logic [1:0] REG_SRC  = 2'd0;
  localparam logic [1:0] REG_DST  = 2'd1;
  localparam logic [1:0] REG_CNT  = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  localparam int B_START = 0;
  localparam int B_EXT   = 1;
  localparam int B_SNOOP = 2;
  localparam int B_YIELD = 3;
  localparam int B_SPER  = 4;
  localparam int B_DPER  = 5;
  localparam int B_SHOLD = 6;
  localparam int B_DHOLD = 7;
  localparam int B_DONE  = 8;
  localparam int B_ERR   = 9;

  typedef struct packed {
    logic dst_hold;
    logic src_hold;
    logic dst_per;
    logic src_per;
    logic yield_en;
    logic snoop_en;
    logic ext_mode;
  } dma_ctrl_t;
endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          word_done,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr,
  output dma_ctrl_t     ctl,
  output logic          start,
  output logic          last,
  output logic          done,
  output logic          err
);
  localparam int STEP = 4;

  logic [CW-1:0] cnt;
  logic [DW-1:0] ctl_word;

  assign last = (cnt == CW'(STEP));

  always_comb begin
    ctl_word          = '0;
    ctl_word[B_START] = start;
    ctl_word[B_EXT]   = ctl.ext_mode;
    ctl_word[B_SNOOP] = ctl.snoop_en;
    ctl_word[B_YIELD] = ctl.yield_en;
    ctl_word[B_SPER]  = ctl.src_per;
    ctl_word[B_DPER]  = ctl.dst_per;
    ctl_word[B_SHOLD] = ctl.src_hold;
    ctl_word[B_DHOLD] = ctl.dst_hold;
    ctl_word[B_DONE]  = done;
    ctl_word[B_ERR]   = err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src_addr <= '0;
      dst_addr <= '0;
      cnt      <= '0;
      ctl      <= '0;
      start    <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else if (word_done) begin
      if (!ctl.src_hold) src_addr <= src_addr + AW'(STEP);
      if (!ctl.dst_hold) dst_addr <= dst_addr + AW'(STEP);
      cnt <= cnt - CW'(STEP);
      if (last) begin
        start <= 1'b0;
        done  <= 1'b1;
      end
    end else if (cfg_we && !start) begin
      case (cfg_addr)
        REG_SRC: src_addr <= AW'(cfg_wdata);
        REG_DST: dst_addr <= AW'(cfg_wdata);
        REG_CNT: cnt      <= CW'(cfg_wdata) & ~CW'(STEP - 1);
        default: begin
          ctl.ext_mode <= cfg_wdata[B_EXT];
          ctl.snoop_en <= cfg_wdata[B_SNOOP];
          ctl.yield_en <= cfg_wdata[B_YIELD];
          ctl.src_per  <= cfg_wdata[B_SPER];
          ctl.dst_per  <= cfg_wdata[B_DPER];
          ctl.src_hold <= cfg_wdata[B_SHOLD];
          ctl.dst_hold <= cfg_wdata[B_DHOLD];
          if (cfg_wdata[B_START]) begin
            if (cfg_wdata[B_SPER] && cfg_wdata[B_DPER]) begin
              err <= 1'b1;
            end else if (cnt == '0) begin
              done <= 1'b1;
              err  <= 1'b0;
            end else begin
              start <= 1'b1;
              done  <= 1'b0;
              err   <= 1'b0;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      case (cfg_addr)
        REG_SRC: cfg_rdata <= DW'(src_addr);
        REG_DST: cfg_rdata <= DW'(dst_addr);
        REG_CNT: cfg_rdata <= DW'(cnt);
        default: cfg_rdata <= ctl_word;
      endcase
    end
  end
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          last,
  input  dma_ctrl_t     ctl,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic          preq_i,
  input  logic          gnt_i,
  input  logic          yield_i,
  input  logic          m_ready_i,
  input  logic [DW-1:0] m_rdata_i,
  output logic          bus_req,
  output logic          m_valid,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  output logic          pack,
  output logic          word_done
);
  dma_state_e state, nxt;
  logic [DW-1:0] hold_buf;
  logic pend;

  assign pend      = start && (!ctl.ext_mode || preq_i);
  assign bus_req   = (state != ST_IDLE);
  assign m_valid   = (state == ST_RD) || (state == ST_WR);
  assign m_we      = (state == ST_WR);
  assign m_addr    = m_we ? dst_addr : src_addr;
  assign m_wdata   = hold_buf;
  assign pack      = ((state == ST_RD) && ctl.src_per) || ((state == ST_WR) && ctl.dst_per);
  assign word_done = (state == ST_WR) && m_ready_i;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (pend) nxt = ST_REQ;
      ST_REQ:  if (gnt_i) nxt = ST_RD;
      ST_RD:   if (m_ready_i) nxt = ST_WR;
      default: begin
        if (m_ready_i) begin
          if (last)                       nxt = ST_IDLE;
          else if (ctl.yield_en && yield_i) nxt = ST_IDLE;
          else if (pend)                  nxt = ST_RD;
          else                            nxt = ST_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      hold_buf <= '0;
    end else begin
      state <= nxt;
      if (state == ST_RD && m_ready_i) hold_buf <= m_rdata_i;
    end
  end
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  output logic          bus_req_o,
  output logic          bus_snoop_o,
  input  logic          bus_gnt_i,
  input  logic          bus_yield_i,
  output logic          m_valid_o,
  output logic          m_we_o,
  output logic [AW-1:0] m_addr_o,
  output logic [DW-1:0] m_wdata_o,
  input  logic [DW-1:0] m_rdata_i,
  input  logic          m_ready_i,
  input  logic          preq_i,
  output logic          pack_o,
  output logic          done_o,
  output logic          err_o
);
  dma_ctrl_t     ctl;
  logic [AW-1:0] src_addr, dst_addr;
  logic          start, last, word_done;
  logic          snoop_en_w, yield_en_w;

  assign snoop_en_w  = ctl.snoop_en;
  assign yield_en_w  = ctl.yield_en;
  assign bus_snoop_o = bus_req_o && snoop_en_w;

  dma_regs #(.DW(DW), .AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .word_done(word_done), .src_addr(src_addr), .dst_addr(dst_addr),
    .ctl(ctl), .start(start), .last(last), .done(done_o), .err(err_o)
  );

  dma_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .last(last), .ctl(ctl),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .preq_i(preq_i), .gnt_i(bus_gnt_i), .yield_i(bus_yield_i),
    .m_ready_i(m_ready_i), .m_rdata_i(m_rdata_i),
    .bus_req(bus_req_o), .m_valid(m_valid_o), .m_we(m_we_o),
    .m_addr(m_addr_o), .m_wdata(m_wdata_o), .pack(pack_o), .word_done(word_done)
  );
endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req_o,
  input logic          bus_snoop_o,
  input logic          bus_gnt_i,
  input logic          bus_yield_i,
  input logic          m_valid_o,
  input logic          m_we_o,
  input logic          m_ready_i,
  input logic [AW-1:0] m_addr_o,
  input logic          pack_o,
  input logic          err_o,
  input logic          yield_en
);
  a_r3_ack_inside_cycle: assert property (@(posedge clk) disable iff (rst)
    pack_o |-> m_valid_o);

  a_r4_cycle_needs_grant: assert property (@(posedge clk) disable iff (rst)
    m_valid_o |-> (bus_req_o && bus_gnt_i));

  a_r5_snoop_with_req: assert property (@(posedge clk) disable iff (rst)
    bus_snoop_o |-> bus_req_o);

  a_r12_hold_in_wait: assert property (@(posedge clk) disable iff (rst)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_addr_o) && $stable(m_we_o)));

  a_r10_write_after_read: assert property (@(posedge clk) disable iff (rst)
    $rose(m_we_o) |-> $past(m_valid_o && !m_we_o && m_ready_i));

  a_r6_yield_release: assert property (@(posedge clk) disable iff (rst)
    (m_valid_o && m_we_o && m_ready_i && bus_yield_i && yield_en) |=> !bus_req_o);

  a_r2_refused_no_req: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o) |-> !bus_req_o);
endmodule

bind dma_chan dma_chan_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .bus_req_o(bus_req_o), .bus_snoop_o(bus_snoop_o),
  .bus_gnt_i(bus_gnt_i), .bus_yield_i(bus_yield_i), .m_valid_o(m_valid_o),
  .m_we_o(m_we_o), .m_ready_i(m_ready_i), .m_addr_o(m_addr_o), .pack_o(pack_o),
  .err_o(err_o), .yield_en(yield_en_w)
);

// File: tb/dma_chan_bench.sv
module dma_chan_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic bus_req_o, bus_snoop_o, m_valid_o, m_we_o, pack_o, done_o, err_o;
  logic bus_gnt_i = 1'b0, bus_yield_i = 1'b0, m_ready_i = 1'b0, preq_i = 1'b0;
  logic [31:0] m_addr_o, m_wdata_o;
  logic [31:0] m_rdata_i = '0;

  always #4 clk = ~clk;

  dma_chan u_dma_chan (.*);

  int checks = 0, errors = 0, cycles = 0;
  logic [31:0] mem [64];
  logic [31:0] snap [64];
  logic [31:0] plog [16];
  int plog_n = 0;
  logic [31:0] pseq = 32'hA000_0000;
  logic gnt_block = 1'b0;
  logic c_sper = 0, c_dper = 0, c_snoop = 0;
  int v_ack = 0, v_gnt = 0, v_snoop = 0, v_wait = 0, drops = 0;
  logic hs_prev = 0, stall_prev = 0, we_prev = 0;
  logic [31:0] addr_prev = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit st, bit ext, bit snp, bit yld,
                                     bit sp, bit dp, bit sh, bit dh);
    return {24'd0, dh, sh, dp, sp, yld, snp, ext, st};
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 2'd3) begin
      c_snoop = d[2]; c_sper = d[4]; c_dper = d[5];
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    @(negedge clk);
    d = cfg_rdata;
  endtask

  task automatic wait_done(int maxc);
    int i;
    for (i = 0; i < maxc && !done_o; i++) @(negedge clk);
    if (!done_o) begin
      errors++;
      $display("FAIL watchdog: done_o actual=0 expected=1");
    end
  endtask

  always @(posedge clk) begin
    if (m_valid_o && m_ready_i) begin
      if (!m_we_o && pack_o) pseq <= pseq + 1;
      if (m_we_o) begin
        if (pack_o) begin
          plog[plog_n[3:0]] <= m_wdata_o;
          plog_n <= plog_n + 1;
        end else begin
          mem[m_addr_o[7:2]] <= m_wdata_o;
        end
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      if (stall_prev && !(m_valid_o && m_addr_o == addr_prev && m_we_o == we_prev)) v_wait++;
      if (hs_prev && !bus_req_o) drops++;
      if (pack_o !== (m_valid_o && ((!m_we_o && c_sper) || (m_we_o && c_dper)))) v_ack++;
      if (bus_snoop_o !== (bus_req_o && c_snoop)) v_snoop++;
    end
    if (!bus_req_o) bus_gnt_i = 1'b0;
    else if (!bus_gnt_i && !gnt_block && ($urandom % 3 == 0)) bus_gnt_i = 1'b1;
    if (!rst && m_valid_o && !bus_gnt_i) v_gnt++;
    m_ready_i = ($urandom % 3 != 0);
    m_rdata_i = (pack_o && !m_we_o) ? pseq : mem[m_addr_o[7:2]];
    hs_prev    = m_valid_o && m_we_o && m_ready_i;
    stall_prev = m_valid_o && !m_ready_i;
    addr_prev  = m_addr_o;
    we_prev    = m_we_o;
  end

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: run did not end");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int nw, s, t, bad;
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // reset state
    check("R4 reset bus_req", {31'd0, bus_req_o}, 32'd0);
    check("R11 reset done", {31'd0, done_o}, 32'd0);
    rd(2'd3, d);
    check("R2 reset ctrl", d, 32'd0);

    // R1 register readback and count masking
    wr(2'd0, 32'h0000_0010);
    wr(2'd1, 32'h0000_0080);
    wr(2'd2, 32'h0000_0013);
    rd(2'd0, d); check("R1 src readback", d, 32'h10);
    rd(2'd1, d); check("R1 dst readback", d, 32'h80);
    rd(2'd2, d); check("R1 count masked", d, 32'h10);

    // R13 zero count
    wr(2'd2, 32'd0);
    wr(2'd3, mk(1,0,0,0,0,0,0,0));
    repeat (3) @(negedge clk);
    check("R13 zero count done", {31'd0, done_o}, 32'd1);
    check("R13 zero count no request", {31'd0, bus_req_o}, 32'd0);

    // R2 peripheral pair refused
    wr(2'd2, 32'd8);
    wr(2'd3, mk(1,0,0,0,1,1,0,0));
    repeat (6) @(negedge clk);
    check("R2 error flag", {31'd0, err_o}, 32'd1);
    check("R2 no request", {31'd0, bus_req_o}, 32'd0);
    rd(2'd3, d);
    check("R2 start stays clear", {31'd0, d[0]}, 32'd0);

    // R8 R10 R11 R5 random memory copies
    for (int k = 0; k < 6; k++) begin
      nw = 1 + $urandom % 6;
      s = $urandom % 16;
      t = 32 + $urandom % 16;
      for (int i = 0; i < 64; i++) snap[i] = mem[i];
      bus_yield_i = $urandom % 2;
      wr(2'd0, s * 4);
      wr(2'd1, t * 4);
      wr(2'd2, nw * 4);
      wr(2'd3, mk(1,0,$urandom % 2,0,0,0,0,0));
      check("R13 start clears done", {31'd0, done_o}, 32'd0);
      wait_done(400);
      bad = 0;
      for (int i = 0; i < nw; i++) if (mem[t + i] !== snap[s + i]) bad++;
      check("R10 copied words mismatch", bad, 0);
      rd(2'd0, d); check("R11 src advanced", d, (s + nw) * 4);
      rd(2'd1, d); check("R11 dst advanced", d, (t + nw) * 4);
      rd(2'd2, d); check("R8 count exhausted", d, 0);
    end
    bus_yield_i = 1'b0;

    // R3 peripheral source with hold
    pseq = 32'hA000_0000;
    wr(2'd0, 32'h0000_0100);
    wr(2'd1, 32'h0000_00C0);
    wr(2'd2, 32'd16);
    wr(2'd3, mk(1,0,0,0,1,0,1,0));
    wait_done(400);
    bad = 0;
    for (int i = 0; i < 4; i++) if (mem[48 + i] !== 32'hA000_0000 + i) bad++;
    check("R3 peripheral read data", bad, 0);
    rd(2'd0, d); check("R11 src held", d, 32'h100);

    // R3 peripheral destination with hold
    for (int i = 0; i < 64; i++) snap[i] = mem[i];
    plog_n = 0;
    wr(2'd0, 32'h0000_0020);
    wr(2'd1, 32'h0000_0200);
    wr(2'd2, 32'd12);
    wr(2'd3, mk(1,0,1,0,0,1,0,1));
    wait_done(400);
    @(negedge clk);
    check("R3 peripheral writes", plog_n, 3);
    bad = 0;
    for (int i = 0; i < 3; i++) if (plog[i] !== snap[8 + i]) bad++;
    check("R3 peripheral write data", bad, 0);
    rd(2'd1, d); check("R11 dst held", d, 32'h200);

    // R6 yield enabled: released after every word
    bus_yield_i = 1'b1;
    drops = 0;
    wr(2'd0, 32'h0); wr(2'd1, 32'h80); wr(2'd2, 32'd16);
    wr(2'd3, mk(1,0,0,1,0,0,0,0));
    wait_done(400);
    @(negedge clk);
    check("R6 yield releases per word", drops, 4);

    // R6 yield disabled: released only at the end
    drops = 0;
    wr(2'd2, 32'd16);
    wr(2'd3, mk(1,0,0,0,0,0,0,0));
    wait_done(400);
    @(negedge clk);
    check("R6 yield ignored", drops, 1);
    bus_yield_i = 1'b0;

    // R9 R7 external level mode
    wr(2'd0, 32'h0); wr(2'd1, 32'h80); wr(2'd2, 32'd12);
    wr(2'd3, mk(1,1,0,0,0,0,0,0));
    repeat (10) @(negedge clk);
    check("R9 no request while preq low", {31'd0, bus_req_o}, 32'd0);
    @(negedge clk); preq_i = 1'b1;
    @(negedge clk); preq_i = 1'b0;
    repeat (40) @(negedge clk);
    check("R7 request dropped", {31'd0, bus_req_o}, 32'd0);
    rd(2'd2, d); check("R9 one word per sample", d, 32'd8);
    preq_i = 1'b1;
    wait_done(400);
    preq_i = 1'b0;
    rd(2'd2, d); check("R9 level mode completes", d, 32'd0);

    // R4 R1 grant withheld, writes locked while active
    gnt_block = 1'b1;
    wr(2'd0, 32'h10); wr(2'd2, 32'd8);
    wr(2'd3, mk(1,0,0,0,0,0,0,0));
    repeat (5) @(negedge clk);
    check("R4 request waits for grant", {31'd0, bus_req_o}, 32'd1);
    check("R4 no cycle without grant", {31'd0, m_valid_o}, 32'd0);
    wr(2'd0, 32'h55);
    rd(2'd0, d); check("R1 write ignored while active", d, 32'h10);
    gnt_block = 1'b0;
    wait_done(400);

    check("R3 ack monitor violations", v_ack, 0);
    check("R4 grant monitor violations", v_gnt, 0);
    check("R5 snoop monitor violations", v_snoop, 0);
    check("R12 wait-state violations", v_wait, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule